// File: doc/BRIEF.md
# Accumulator Decimal Adjust Unit

This block applies the decimal correction that follows a binary add or subtract of BCD digits held in an 8-bit accumulator pair (a low byte and a high byte). It covers four corrections, chosen by a 2-bit operation code. Two work on packed BCD, with two digits per byte. The other two work on unpacked BCD, with one digit per byte and the carry going into the high byte.

The caller presents the low byte, the high byte, the incoming carry and auxiliary-carry flags, and the operation code, then pulses `start` for one cycle. At that clock edge the block registers the corrected bytes and the carry, auxiliary-carry, sign and zero flags. It raises `done` for exactly one cycle. The registered results hold until the next start.

Packed corrections are done in two steps. The high-digit test looks at the byte as it stands after the low-digit correction, not at the original byte.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `lo_out`, `hi_out`, `cf_out`, `af_out`, `sf_out`, `zf_out` and `done` all become 0.
- R2: `done` is 1 in the cycle after a cycle with `start` high and 0 otherwise. The results of that start are visible on the outputs in that same cycle.
- R3: In cycles without `start`, every result output keeps its value.
- R4: Packed add (op = 2'b00), low step: if bits [3:0] of `lo_in` exceed 9 or `af_in` is 1, the byte is increased by 0x06 and `af_out` is 1. Otherwise the byte is unchanged and `af_out` is 0.
- R5: Packed add, high step: if the byte left by the low step exceeds 0x9F or `cf_in` is 1, the byte is increased by 0x60 (modulo 256) and `cf_out` is 1. Otherwise `cf_out` is 0.
- R6: Packed subtract (op = 2'b01) uses the same two tests as R4 and R5, but subtracts 0x06 and 0x60 (modulo 256). It sets `af_out` and `cf_out` the same way.
- R7: For both packed operations, `sf_out` equals bit 7 of the final low byte. `zf_out` is 1 exactly when the final low byte is 0.
- R8: Unpacked add (op = 2'b10): if `af_in` is 1 or bits [3:0] of `lo_in` exceed 9, the result is `lo_out` = (`lo_in`+6) & 0x0F and `hi_out` = `hi_in`+1, with `af_out` = `cf_out` = 1. Otherwise `lo_out` = `lo_in` & 0x0F, `hi_out` = `hi_in`, and both flags are 0.
- R9: Unpacked subtract (op = 2'b11), under the same test as R8: `lo_out` = (`lo_in`−6) & 0x0F and `hi_out` = `hi_in`−1. `hi_out` is decreased by one more when `lo_in` < 6. Both `af_out` and `cf_out` are 1. Otherwise `lo_out` = `lo_in` & 0x0F, `hi_out` = `hi_in`, and both flags are 0.
- R10: Unpacked operations leave `sf_out` and `zf_out` at their previous values. Packed operations pass `hi_in` to `hi_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to correct the presented operands |
| op | input | 2 | 00 packed add, 01 packed subtract, 10 unpacked add, 11 unpacked subtract |
| lo_in | input | 8 | Low accumulator byte |
| hi_in | input | 8 | High accumulator byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| lo_out | output | 8 | Corrected low byte |
| hi_out | output | 8 | Corrected high byte |
| cf_out | output | 1 | Resulting carry flag |
| af_out | output | 1 | Resulting auxiliary-carry flag |
| sf_out | output | 1 | Resulting sign flag |
| zf_out | output | 1 | Resulting zero flag |
| done | output | 1 | One-cycle pulse marking fresh results |

## Verification
A packed high-step test that looked at the original byte rather than the corrected one would differ only on operands such as 0x9A to 0x9F with no carry in. The directed cases target those operands, and the wrong result shows on `lo_out` and `cf_out` in the cycle after start. A wrong borrow in the unpacked subtract shows on `hi_out` in the same cycle. A sign or zero register updated when it should hold shows up only on a later unpacked operation, so the random sequence mixes the four operations back to back.

// File: rtl/bcd_adj_pkg.sv
// Shared constants and operation encoding for the decimal adjust unit.
// Assumes byte-wide accumulator halves and 4-bit BCD digits.
package bcd_adj_pkg;
    localparam int BYTE_W  = 8;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;
    localparam logic [BYTE_W-1:0]  LOW_FIX   = 8'h06;
    localparam logic [BYTE_W-1:0]  HIGH_FIX  = 8'h60;
    localparam logic [BYTE_W-1:0]  HIGH_LIM  = 8'h9F;

    typedef enum logic [1:0] {
        OP_PACK_ADD = 2'b00,
        OP_PACK_SUB = 2'b01,
        OP_UNPK_ADD = 2'b10,
        OP_UNPK_SUB = 2'b11
    } adj_op_e;
endpackage

// File: rtl/bcd_packed_corr.sv
// Two-step packed BCD correction (combinational).
// The high-digit test examines the byte after the low-digit step.
// Assumes: is_sub selects subtraction of the correction constants.
module bcd_packed_corr
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              cf_i,
    input  logic              af_i,
    input  logic              is_sub,
    output logic [BYTE_W-1:0] lo_o,
    output logic              cf_o,
    output logic              af_o
);
    logic [BYTE_W-1:0] stage1;
    logic              low_hit;
    logic              high_hit;

    // Low-digit step: add or subtract six when the digit is out of range.
    always_comb begin
        low_hit = (lo_i[DIGIT_W-1:0] > DIGIT_MAX) || af_i;
        if (low_hit) stage1 = is_sub ? (lo_i - LOW_FIX) : (lo_i + LOW_FIX);
        else         stage1 = lo_i;
        af_o = low_hit;
    end

    // High-digit step: test the already corrected byte.
    always_comb begin
        high_hit = (stage1 > HIGH_LIM) || cf_i;
        if (high_hit) lo_o = is_sub ? (stage1 - HIGH_FIX) : (stage1 + HIGH_FIX);
        else          lo_o = stage1;
        cf_o = high_hit;
    end
endmodule

// File: rtl/bcd_unpacked_corr.sv
// Single-digit (unpacked) BCD correction (combinational).
// The carry or borrow ripples into the high byte. The low byte is reduced to
// one digit. Subtract applies an extra high-byte borrow when lo_i < 6.
module bcd_unpacked_corr
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              af_i,
    input  logic              is_sub,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              adj_o
);
    localparam logic [BYTE_W-1:0] DIGIT_MASK = {{(BYTE_W-DIGIT_W){1'b0}}, {DIGIT_W{1'b1}}};

    logic [BYTE_W-1:0] lo_adj;
    logic              low_borrow;

    // Digit correction and high-byte carry/borrow.
    always_comb begin
        adj_o      = af_i || (lo_i[DIGIT_W-1:0] > DIGIT_MAX);
        low_borrow = is_sub && (lo_i < LOW_FIX);
        lo_adj     = lo_i;
        hi_o       = hi_i;
        if (adj_o) begin
            if (is_sub) begin
                lo_adj = lo_i - LOW_FIX;
                hi_o   = hi_i - 8'd1 - {7'd0, low_borrow};
            end else begin
                lo_adj = lo_i + LOW_FIX;
                hi_o   = hi_i + 8'd1;
            end
        end
        lo_o = lo_adj & DIGIT_MASK;
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
// Accumulator decimal adjust unit: selects a packed or unpacked correction,
// registers the result on a start strobe and pulses done one cycle later.
// Assumes start is a single-cycle strobe. Synchronous active-low reset.
module bcd_adjust_unit
    import bcd_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    input  logic              cf_in,
    input  logic              af_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out,
    output logic              cf_out,
    output logic              af_out,
    output logic              sf_out,
    output logic              zf_out,
    output logic              done
);
    logic [BYTE_W-1:0] pk_lo;
    logic              pk_cf;
    logic              pk_af;
    logic [BYTE_W-1:0] up_lo;
    logic [BYTE_W-1:0] up_hi;
    logic              up_adj;
    logic              is_unpacked;

    assign is_unpacked = op[1];

    bcd_packed_corr u_packed (
        .lo_i   (lo_in),
        .cf_i   (cf_in),
        .af_i   (af_in),
        .is_sub (op[0]),
        .lo_o   (pk_lo),
        .cf_o   (pk_cf),
        .af_o   (pk_af)
    );

    bcd_unpacked_corr u_unpacked (
        .lo_i   (lo_in),
        .hi_i   (hi_in),
        .af_i   (af_in),
        .is_sub (op[0]),
        .lo_o   (up_lo),
        .hi_o   (up_hi),
        .adj_o  (up_adj)
    );

    // Result register: capture on start, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_out <= '0;
            hi_out <= '0;
            cf_out <= 1'b0;
            af_out <= 1'b0;
            sf_out <= 1'b0;
            zf_out <= 1'b0;
        end else if (start) begin
            if (is_unpacked) begin
                lo_out <= up_lo;
                hi_out <= up_hi;
                cf_out <= up_adj;
                af_out <= up_adj;
            end else begin
                lo_out <= pk_lo;
                hi_out <= hi_in;
                cf_out <= pk_cf;
                af_out <= pk_af;
                sf_out <= pk_lo[BYTE_W-1];
                zf_out <= (pk_lo == '0);
            end
        end
    end

    // Completion pulse one cycle after start.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= start;
    end
endmodule

// File: rtl/bcd_adjust_chk.sv
// Temporal checks on the decimal adjust unit ports, bound to the top module.
module bcd_adjust_chk
    import bcd_adj_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op,
    input logic [BYTE_W-1:0] lo_in,
    input logic [BYTE_W-1:0] hi_in,
    input logic [BYTE_W-1:0] lo_out,
    input logic [BYTE_W-1:0] hi_out,
    input logic              cf_out,
    input logic              af_out,
    input logic              sf_out,
    input logic              zf_out,
    input logic              done
);
    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(lo_out) && $stable(hi_out) && $stable(cf_out)
                    && $stable(af_out) && $stable(sf_out) && $stable(zf_out)));
    // R4
    packed_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_PACK_ADD && lo_in[3:0] > 4'd9) |=> af_out);
    // R7
    packed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op[1]) |=> (sf_out == lo_out[BYTE_W-1] && zf_out == (lo_out == '0)));
    // R8
    unpacked_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1]) |=> (lo_out[BYTE_W-1:DIGIT_W] == '0 && af_out == cf_out));
    // R10
    unpacked_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1]) |=> ($stable(sf_out) && $stable(zf_out)));
    // R10
    packed_hi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op[1]) |=> (hi_out == $past(hi_in)));
endmodule

bind bcd_adjust_unit bcd_adjust_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .lo_in  (lo_in),
    .hi_in  (hi_in),
    .lo_out (lo_out),
    .hi_out (hi_out),
    .cf_out (cf_out),
    .af_out (af_out),
    .sf_out (sf_out),
    .zf_out (zf_out),
    .done   (done)
);

// File: tb/bcd_adjust_unit_test.sv
module bcd_adjust_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] lo_in = 8'h00;
    logic [7:0] hi_in = 8'h00;
    logic       cf_in = 1'b0;
    logic       af_in = 1'b0;
    logic [7:0] lo_out;
    logic [7:0] hi_out;
    logic       cf_out, af_out, sf_out, zf_out, done;

    int checks = 0;
    int fails  = 0;
    logic m_sf = 1'b0;
    logic m_zf = 1'b0;

    always #2 clk = ~clk;

    bcd_adjust_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .lo_in(lo_in), .hi_in(hi_in), .cf_in(cf_in), .af_in(af_in),
        .lo_out(lo_out), .hi_out(hi_out), .cf_out(cf_out), .af_out(af_out),
        .sf_out(sf_out), .zf_out(zf_out), .done(done)
    );

    // Reference model: returns {lo, hi, cf, af, sf, zf}.
    function automatic logic [19:0] model(input logic [1:0] o, input logic [7:0] a,
        input logic [7:0] h, input logic c, input logic x, input logic ps, input logic pz);
        logic [7:0] r = a;
        logic [7:0] rh = h;
        logic rc = 1'b0, rx = 1'b0, rs = ps, rz = pz;
        if (o[1] == 1'b0) begin
            if (a[3:0] > 4'd9 || x) begin
                r = o[0] ? r - 8'h06 : r + 8'h06;
                rx = 1'b1;
            end
            if (r > 8'h9F || c) begin
                r = o[0] ? r - 8'h60 : r + 8'h60;
                rc = 1'b1;
            end
            rs = r[7];
            rz = (r == 8'h00);
        end else begin
            if (x || a[3:0] > 4'd9) begin
                rx = 1'b1; rc = 1'b1;
                if (o[0]) begin
                    r  = a - 8'd6;
                    rh = h - 8'd1;
                    if (a < 8'd6) rh = rh - 8'd1;
                end else begin
                    r  = a + 8'd6;
                    rh = h + 8'd1;
                end
            end
            r = r & 8'h0F;
        end
        return {r, rh, rc, rx, rs, rz};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: strobe at a falling edge, check at the following one.
    task automatic run_op(input string req, input logic [1:0] o, input logic [7:0] a,
        input logic [7:0] h, input logic c, input logic x);
        logic [19:0] e;
        e = model(o, a, h, c, x, m_sf, m_zf);
        op = o; lo_in = a; hi_in = h; cf_in = c; af_in = x; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R2 done"}, {31'd0, done}, 32'd1);
        check({req, " result"}, {12'd0, lo_out, hi_out, cf_out, af_out, sf_out, zf_out},
              {12'd0, e});
        m_sf = e[1]; m_zf = e[0];
        lo_in = ~a; hi_in = ~h; cf_in = ~c; af_in = ~x;
        @(negedge clk);
        check("R3 hold/R2 done low", {11'd0, done, lo_out, hi_out, cf_out, af_out, sf_out, zf_out},
              {11'd0, 1'b0, e});
    endtask

    initial begin
        #40000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        check("R1 reset", {13'd0, done, lo_out, hi_out, cf_out, af_out, sf_out, zf_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 low step only
        run_op("R4", 2'b00, 8'h0B, 8'h11, 1'b0, 1'b0);
        // R5 high step on corrected value: 0x9F -> 0xA5 -> 0x05 with carry
        run_op("R5", 2'b00, 8'h9F, 8'h00, 1'b0, 1'b0);
        // R5 + R7 zero result: 0x9A -> 0xA0 -> 0x00
        run_op("R5 R7 zero", 2'b00, 8'h9A, 8'h22, 1'b0, 1'b0);
        // R4 no correction
        run_op("R4 none", 2'b00, 8'h45, 8'h00, 1'b0, 1'b0);
        // R6 packed subtract with both steps
        run_op("R6", 2'b01, 8'hAF, 8'h00, 1'b0, 1'b0);
        run_op("R6 carry in", 2'b01, 8'h03, 8'h00, 1'b1, 1'b1);
        // R8 unpacked add
        run_op("R8", 2'b10, 8'h0C, 8'h05, 1'b0, 1'b0);
        run_op("R8 none", 2'b10, 8'h37, 8'h05, 1'b1, 1'b0);
        // R9 unpacked subtract with extra borrow and without
        run_op("R9 borrow", 2'b11, 8'h03, 8'h05, 1'b0, 1'b1);
        run_op("R9", 2'b11, 8'h0F, 8'h00, 1'b0, 1'b0);
        run_op("R9 none", 2'b11, 8'hF8, 8'h40, 1'b1, 1'b0);
        // R10 sign/zero hold: packed sets, unpacked must keep
        run_op("R7", 2'b00, 8'h80, 8'h00, 1'b0, 1'b0);
        run_op("R10 hold", 2'b10, 8'h00, 8'h00, 1'b0, 1'b0);
        for (int i = 0; i < 400; i++) begin
            run_op("R4-R10 random", 2'($urandom), 8'($urandom), 8'($urandom),
                   1'($urandom), 1'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule